// File: doc/BRIEF.md
# SHA-1 Single-Block MAC Coprocessor

A bus-attached engine that computes a SHA-1 based authentication code over one 512-bit block. The host fills a sixteen-word message window through a synchronous 32-bit port, then pulses a start input. The engine runs the 80-round SHA-1 compression at one round per clock and holds a busy flag high throughout. It then exposes the five working variables as read-only result words. The host compares those words against the code returned by the device under test. Padding, chaining of several blocks, protection of the secret and the comparison itself are left to the host.

The result words are the raw working variables after round 79. The five initial chaining constants are not added to them. The message window doubles as the circular schedule store, so a computation overwrites it. The host resets the block and reloads all sixteen words before each run. It must not access the port while busy is high.

Top module: `sha1_mac_cop`

## Requirements
- R1: Word addresses 00h..0Fh are a read/write message window: address n holds message word n, and bits 31:24 of each word carry its lowest-addressed message byte.
- R2: After a computation, addresses 10h..14h read A, B, C, D and E respectively, i.e. the raw working variables after 80 standard SHA-1 rounds started from 67452301h, EFCDAB89h, 98BADCFEh, 10325476h, C3D2E1F0h, with no initial constants added.
- R3: A port access takes place only in a cycle where cs_ni is low at the rising edge; it is a write when we_ni is also low and a read otherwise. rdata_o is registered: in the cycle after a read it holds the addressed word, and in the cycle after any cycle without a read it is zero.
- R4: A start_i pulse while idle raises busy_o in the next cycle, and busy_o then stays high for exactly 80 cycles.
- R5: A start_i pulse while busy_o is high is ignored: the running computation neither restarts nor lengthens, and its result is unchanged.
- R6: Reads of addresses 15h..1Fh return zero. Writes to any address from 10h to 1Fh leave every readable word unchanged.
- R7: rst_ni low clears busy_o and forces the result words to zero, even during a computation; they read zero until the next computation finishes.
- R8: With word 0 = 61626380h, word 15 = 00000018h and all other words zero, the results are A=42541B35h, B=5738D5E1h, C=21834873h, D=681E6DF6h, E=D8FDF6ADh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset |
| cs_ni | input | 1 | Active-low select; an access needs it low |
| we_ni | input | 1 | Active-low write enable, qualified by cs_ni |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| start_i | input | 1 | One-cycle pulse that starts a compression |
| rdata_o | output | 32 | Registered read data |
| busy_o | output | 1 | High while the compression runs |

## Verification
The bench builds the block with its default sizes: sixteen message words, five result words and 80 rounds. With a 5-bit address, every unmapped address from 15h to 1Fh can then be reached and tested. The known-answer block and several patterned blocks cross all four round-function phase boundaries, and an in-bench SHA-1 model gives the expected words. A second start pulse injected mid-run and a reset during a run cover the ignore and abort cases.

// File: rtl/sha1_mac_pkg.sv
package sha1_mac_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int RES_WORDS = 5;
  localparam int ROUNDS    = 80;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RES_WORDS-1:0][WORD_W-1:0] state_t;

  // index 0 = A ... index 4 = E
  localparam state_t INIT_STATE = {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE,
                                   32'hEFCDAB89, 32'h67452301};

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t round_f(input logic [1:0] ph, input word_t b, input word_t c,
                                    input word_t d);
    case (ph)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic word_t round_k(input logic [1:0] ph);
    case (ph)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
  import sha1_mac_pkg::*;
#(
  parameter int WORDS = MSG_WORDS,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  word_t            wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output word_t            rd_data_o,
  input  logic             step_i,
  input  logic             expand_i,
  input  logic [IDX_W-1:0] step_idx_i,
  output word_t            w_o
);
  word_t mem_q [WORDS];
  word_t mix;

  // taps t-3, t-8, t-14, t-16 of a circular window
  assign mix = mem_q[step_idx_i + IDX_W'(WORDS - 3)] ^
               mem_q[step_idx_i + IDX_W'(WORDS - 8)] ^
               mem_q[step_idx_i + IDX_W'(WORDS - 14)] ^
               mem_q[step_idx_i];
  assign w_o       = expand_i ? rotl(mix, 1) : mem_q[step_idx_i];
  assign rd_data_o = mem_q[rd_idx_i];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (step_i && expand_i && step_idx_i == IDX_W'(g)) begin
        mem_q[g] <= w_o;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
  import sha1_mac_pkg::*;
#(
  parameter int NUM_ROUNDS = ROUNDS,
  parameter int WIN_WORDS  = MSG_WORDS,
  localparam int RND_W  = $clog2(NUM_ROUNDS),
  localparam int IDX_W  = $clog2(WIN_WORDS),
  localparam int PH_LEN = NUM_ROUNDS / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  word_t            w_i,
  output logic             busy_o,
  output logic             step_o,
  output logic             expand_o,
  output logic [IDX_W-1:0] step_idx_o,
  output state_t           state_o
);
  logic             busy_q;
  logic [RND_W-1:0] rnd_q;
  state_t           st_q, st_nxt;
  logic [1:0]       ph;
  word_t            tmp;

  always_comb begin
    if (rnd_q < RND_W'(PH_LEN))          ph = 2'd0;
    else if (rnd_q < RND_W'(2 * PH_LEN)) ph = 2'd1;
    else if (rnd_q < RND_W'(3 * PH_LEN)) ph = 2'd2;
    else                                 ph = 2'd3;
  end

  always_comb begin
    tmp = rotl(st_q[0], 5) + round_f(ph, st_q[1], st_q[2], st_q[3]) + st_q[4] +
          round_k(ph) + w_i;
    st_nxt = {st_q[3], st_q[2], rotl(st_q[1], 30), st_q[0], tmp};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      st_q   <= '0;
    end else if (busy_q) begin
      st_q  <= st_nxt;
      rnd_q <= rnd_q + RND_W'(1);
      if (rnd_q == RND_W'(NUM_ROUNDS - 1)) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rnd_q  <= '0;
      st_q   <= INIT_STATE;
    end
  end

  assign busy_o     = busy_q;
  assign step_o     = busy_q;
  assign expand_o   = rnd_q >= RND_W'(WIN_WORDS);
  assign step_idx_o = rnd_q[IDX_W-1:0];
  assign state_o    = st_q;
endmodule

// File: rtl/sha1_bus_port.sv
module sha1_bus_port
  import sha1_mac_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BUF_WDS = MSG_WORDS,
  parameter int RES_WDS = RES_WORDS,
  localparam int IDX_W  = $clog2(BUF_WDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  word_t             buf_rd_i,
  input  state_t            res_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output word_t             rdata_o
);
  logic  in_buf;
  logic  rd_acc;
  word_t rd_mux;
  word_t rdata_q;

  assign in_buf  = addr_i < ADDR_W'(BUF_WDS);
  assign idx_o   = addr_i[IDX_W-1:0];
  assign rd_acc  = !cs_ni && we_ni;
  assign wr_en_o = !cs_ni && !we_ni && in_buf && !busy_i;

  always_comb begin
    rd_mux = '0;
    if (in_buf) rd_mux = buf_rd_i;
    for (int i = 0; i < RES_WDS; i++) begin
      if (addr_i == ADDR_W'(BUF_WDS + i)) rd_mux = res_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sha1_mac_cop.sv
module sha1_mac_cop
  import sha1_mac_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int IDX_W = $clog2(MSG_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              start_i,
  output logic [31:0]       rdata_o,
  output logic              busy_o
);
  logic             wr_en, step, expand;
  logic [IDX_W-1:0] bus_idx, step_idx;
  word_t            buf_rd, w_cur;
  state_t           res_q;

  sha1_bus_port #(
    .ADDR_W (ADDR_W),
    .BUF_WDS(MSG_WORDS),
    .RES_WDS(RES_WORDS)
  ) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .we_ni   (we_ni),
    .addr_i  (addr_i),
    .busy_i  (busy_o),
    .buf_rd_i(buf_rd),
    .res_i   (res_q),
    .wr_en_o (wr_en),
    .idx_o   (bus_idx),
    .rdata_o (rdata_o)
  );

  sha1_msg_window #(.WORDS(MSG_WORDS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (bus_idx),
    .wr_data_i (wdata_i),
    .rd_idx_i  (bus_idx),
    .rd_data_o (buf_rd),
    .step_i    (step),
    .expand_i  (expand),
    .step_idx_i(step_idx),
    .w_o       (w_cur)
  );

  sha1_round_core #(
    .NUM_ROUNDS(ROUNDS),
    .WIN_WORDS (MSG_WORDS)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .w_i       (w_cur),
    .busy_o    (busy_o),
    .step_o    (step),
    .expand_o  (expand),
    .step_idx_o(step_idx),
    .state_o   (res_q)
  );
endmodule

// File: rtl/sha1_mac_cop_chk.sv
module sha1_mac_cop_chk
  import sha1_mac_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(ROUNDS) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              we_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              start_i,
  input logic [31:0]       rdata_o,
  input logic              busy_o,
  input state_t            res_i
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (busy_o) cnt_q <= cnt_q + CNT_W'(1);
    else             cnt_q <= '0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cnt_q == CNT_W'(ROUNDS));

  // R5
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < CNT_W'(ROUNDS));

  // R4
  start_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(res_i));

  // R6
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && we_ni && addr_i >= ADDR_W'(MSG_WORDS + RES_WORDS)) |=> rdata_o == '0);

  // R3
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> rdata_o == '0);

  // R7
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && res_i == '0));
endmodule

bind sha1_mac_cop sha1_mac_cop_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_ni  (cs_ni),
  .we_ni  (we_ni),
  .addr_i (addr_i),
  .start_i(start_i),
  .rdata_o(rdata_o),
  .busy_o (busy_o),
  .res_i  (res_q)
);

// File: tb/tb_sha1_mac_cop.sv
module tb_sha1_mac_cop;
  logic        clk_i = 1'b0;
  logic        rst_ni, cs_ni, we_ni, start_i;
  logic [4:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic        busy_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  sha1_mac_cop dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .we_ni  (we_ni),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .start_i(start_i),
    .rdata_o(rdata_o),
    .busy_o (busy_o)
  );

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w15;
    logic [31:0] fill;
    logic [31:0] step;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{32'h61626380, 32'h00000018, 32'h00000000, 32'h00000000},
    '{32'h00000000, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'h01020304},
    '{32'hDEADBEEF, 32'h00000000, 32'h00000000, 32'h11111111},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
  };

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] msg_word(input vec_t v, input int i);
    if (i == 0)  return v.w0;
    if (i == 15) return v.w15;
    return v.fill + (v.step * 32'(i));
  endfunction

  // reference: raw A..E after 80 rounds, index 0 = A
  function automatic logic [4:0][31:0] ref_raw(input vec_t v);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = msg_word(v, i);
    for (int i = 16; i < 80; i++) w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rol(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rol(b, 30); b = a; a = t;
    end
    return {e, d, c, b, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cyc();
    cyc();
    rst_ni = 1'b1;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    cs_ni = 1'b0; we_ni = 1'b0; addr_i = a; wdata_i = d;
    cyc();
    cs_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    cs_ni = 1'b0; we_ni = 1'b1; addr_i = a;
    cyc();
    d = rdata_o;
    cs_ni = 1'b1;
  endtask

  task automatic run(input bit inject, output int n);
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    chk("R4 busy after start", 32'(busy_o), 32'd1);
    n = 0;
    while (busy_o && n < 1000) begin
      if (inject && n == 40) start_i = 1'b1;
      cyc();
      start_i = 1'b0;
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, keep;
    logic [4:0][31:0] exp_res;
    int n;
    rst_ni = 1'b0; cs_ni = 1'b1; we_ni = 1'b1; start_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    @(negedge clk_i);
    cyc();
    rst_ni = 1'b1;

    // reset state
    chk("R7 busy after reset", 32'(busy_o), 32'd0);
    chk("R3 rdata after reset", rdata_o, 32'd0);
    for (int i = 0; i < 5; i++) begin
      bus_rd(5'(16 + i), rd);
      chk("R7 result zero after reset", rd, 32'd0);
    end

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      for (int i = 0; i < 16; i++) bus_wr(5'(i), msg_word(VECS[v], i));
      bus_rd(5'd0, rd);
      chk("R1 readback word 0", rd, VECS[v].w0);
      bus_rd(5'd15, rd);
      chk("R1 readback word 15", rd, VECS[v].w15);
      bus_rd(5'd7, rd);
      chk("R1 readback word 7", rd, msg_word(VECS[v], 7));
      run(v == 1, n);
      chk(v == 1 ? "R5 busy length with second start" : "R4 busy length", 32'(n), 32'd80);
      exp_res = ref_raw(VECS[v]);
      for (int i = 0; i < 5; i++) begin
        bus_rd(5'(16 + i), rd);
        chk(v == 1 ? "R5 result after ignored start" : "R2 result word", rd, exp_res[i]);
        if (v == 0) begin
          case (i)
            0: chk("R8 known A", rd, 32'h42541B35);
            1: chk("R8 known B", rd, 32'h5738D5E1);
            2: chk("R8 known C", rd, 32'h21834873);
            3: chk("R8 known D", rd, 32'h681E6DF6);
            default: chk("R8 known E", rd, 32'hD8FDF6AD);
          endcase
        end
      end
    end

    // results of last vector still present
    exp_res = ref_raw(VECS[NVEC-1]);
    bus_wr(5'h10, 32'h12345678);
    bus_wr(5'h14, 32'h9ABCDEF0);
    bus_rd(5'h10, rd);
    chk("R6 write to result A ignored", rd, exp_res[0]);
    bus_rd(5'h14, rd);
    chk("R6 write to result E ignored", rd, exp_res[4]);
    bus_wr(5'h15, 32'hCAFEF00D);
    bus_rd(5'h15, rd);
    chk("R6 read 15h zero", rd, 32'd0);
    bus_wr(5'h1F, 32'h0BADF00D);
    bus_rd(5'h1F, rd);
    chk("R6 read 1Fh zero", rd, 32'd0);
    bus_rd(5'h11, rd);
    chk("R6 result B unchanged", rd, exp_res[1]);

    // rdata returns to zero after an idle cycle
    bus_rd(5'h12, rd);
    cyc();
    chk("R3 rdata zero after idle", rdata_o, 32'd0);

    // write enable without select
    bus_rd(5'd3, keep);
    cs_ni = 1'b1; we_ni = 1'b0; addr_i = 5'd3; wdata_i = ~keep;
    cyc();
    we_ni = 1'b1;
    bus_rd(5'd3, rd);
    chk("R3 unselected write ignored", rd, keep);

    // reset in the middle of a computation
    do_reset();
    for (int i = 0; i < 16; i++) bus_wr(5'(i), msg_word(VECS[0], i));
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    repeat (10) cyc();
    do_reset();
    chk("R7 busy cleared by reset", 32'(busy_o), 32'd0);
    bus_rd(5'h10, rd);
    chk("R7 result A cleared by reset", rd, 32'd0);
    bus_rd(5'h13, rd);
    chk("R7 result D cleared by reset", rd, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule